// File: doc/BRIEF.md
# Programmed-Transfer Buffer Ready Tracker

This block keeps the two "buffer ready" flags of a card host controller's data buffer when transfers run without DMA. During a read the card side deposits one whole block into the buffer and signals it with a block-complete strobe. The host then drains that block one 32-bit word at a time through its data port. During a write the host fills the buffer word by word, and the card side signals when it has taken the block away. The flags move only on whole-block boundaries. Every rising edge of a flag comes with a one-cycle interrupt pulse.

A transfer starts with a one-cycle start strobe. The strobe captures the direction, the DMA selection and the number of blocks. The block size in words is held stable by the surrounding logic for the whole transfer. A host access that finds the matching flag low is discarded and reported on an error pulse.

Top module: `buf_ready_tracker`

## Requirements
- R1: After reset `rd_en`, `wr_en`, `rd_ready_irq`, `wr_ready_irq` and `host_err` are all 0.
- R2: In a non-DMA read transfer with blocks remaining, a `card_blk_done` sampled while `rd_en` is 0 makes `rd_en` 1 from the next clock edge. `rd_ready_irq` is 1 for exactly that first cycle.
- R3: Once set, `rd_en` stays 1 through the first N-1 accepted host reads and is 0 after the Nth, where N is `blk_words` (a value of 0 counts as 1).
- R4: A start strobe for a non-DMA write transfer with `blk_total` > 0 makes `wr_en` 1 two clock edges after the strobe is sampled. `wr_ready_irq` is 1 for exactly that first cycle.
- R5: `wr_en` falls after the Nth accepted host write. A later `card_blk_done` sampled while `wr_en` is 0 re-raises it with a `wr_ready_irq` pulse, provided blocks remain.
- R6: The remaining-block count is loaded from `blk_total` at start and is reduced by one at each block completed through the host port. At zero, neither flag rises again.
- R7: In a DMA transfer (`dma_mode` = 1 at start) both flags stay 0, no interrupt pulse occurs, and `card_blk_done` has no effect.
- R8: A host read while `rd_en` is 0, or a host write while `wr_en` is 0, is ignored: it does not advance the word count. `host_err` is 1 for the following cycle.
- R9: A `card_blk_done` during a read while `rd_en` is 1, including in the same cycle as the last host read of the block, is held. After the block is drained, `rd_en` is 0 for one cycle and then rises with `rd_ready_irq`, if blocks remain.
- R10: A `card_blk_done` during a write while `wr_en` is 1 is discarded. It does not cause a later rise.
- R11: A start strobe clears both flags and the word count at once, including in the middle of a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_start | input | 1 | One-cycle start of a transfer |
| xfer_dir_rd | input | 1 | Direction at start: 1 = read (card to host), 0 = write |
| dma_mode | input | 1 | DMA selection at start; flags suppressed when 1 |
| blk_words | input | SIZE_W | Words per block, held stable during a transfer |
| blk_total | input | CNT_W | Number of blocks, captured at start |
| card_blk_done | input | 1 | Card side finished moving one block |
| host_rd | input | 1 | Host reads one word from the data port |
| host_wr | input | 1 | Host writes one word to the data port |
| rd_en | output | 1 | Buffer holds a complete block to read |
| wr_en | output | 1 | Buffer can accept a new block |
| rd_ready_irq | output | 1 | One-cycle pulse on the rise of `rd_en` |
| wr_ready_irq | output | 1 | One-cycle pulse on the rise of `wr_en` |
| host_err | output | 1 | One-cycle pulse after an ignored host access |

## Verification
During a read, the card can report the next block in the very cycle the host takes the last word of the current one. The flag must then fall and re-rise rather than stay high. The bench provokes this directly by driving `host_rd` and `card_blk_done` together on the last word. It expects `rd_en` to be 0 for exactly one cycle and then to return to 1 together with `rd_ready_irq`. Random traffic makes the same collision happen many more times, and a bench-side model of the flag rules judges every cycle.

// File: rtl/buf_trk_pkg.sv
package buf_trk_pkg;

  typedef enum logic {
    DIR_WRITE = 1'b0,
    DIR_READ  = 1'b1
  } xfer_dir_e;

  localparam int NUM_DIR = 2;

  // A block size of zero is treated as one word.
  function automatic int unsigned eff_words(input int unsigned size);
    return (size == 0) ? 1 : size;
  endfunction

  // True when the access now being accepted completes the block.
  function automatic logic is_last_word(input int unsigned cnt,
                                        input int unsigned size);
    return (cnt + 1) >= eff_words(size);
  endfunction

endpackage

// File: rtl/btk_word_ctr.sv
module btk_word_ctr #(
  parameter int SIZE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              acc,
  input  logic [SIZE_W-1:0] size,
  output logic              blk_last
);
  import buf_trk_pkg::*;

  logic [SIZE_W-1:0] cnt;

  always_comb blk_last = acc && is_last_word(32'(cnt), 32'(size));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (clr)      cnt <= '0;
    else if (blk_last) cnt <= '0;
    else if (acc)      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/btk_blk_ctr.sv
module btk_blk_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             left_nz
);
  logic [CNT_W-1:0] left;

  always_comb left_nz = (left != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left <= '0;
    else if (load)           left <= load_val;
    else if (dec && left_nz) left <= left - 1'b1;
  end
endmodule

// File: rtl/btk_flag.sv
module btk_flag #(
  parameter bit QUEUE_WHILE_SET = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic arm,
  input  logic ena,
  input  logic event_in,
  input  logic blk_done,
  input  logic left_nz,
  output logic flag,
  output logic irq
);
  logic pend;
  logic set;
  logic hold_evt;

  always_comb begin
    set      = ena && !flag && (event_in || pend) && left_nz;
    hold_evt = QUEUE_WHILE_SET && ena && event_in && flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      irq  <= 1'b0;
      pend <= 1'b0;
    end else if (clr) begin
      flag <= 1'b0;
      irq  <= 1'b0;
      pend <= arm;
    end else begin
      irq <= set;
      if (set)                 flag <= 1'b1;
      else if (ena && blk_done) flag <= 1'b0;
      if (set)           pend <= 1'b0;
      else if (hold_evt) pend <= 1'b1;
    end
  end
endmodule

// File: rtl/buf_ready_tracker.sv
module buf_ready_tracker #(
  parameter int SIZE_W = 12,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_start,
  input  logic              xfer_dir_rd,
  input  logic              dma_mode,
  input  logic [SIZE_W-1:0] blk_words,
  input  logic [CNT_W-1:0]  blk_total,
  input  logic              card_blk_done,
  input  logic              host_rd,
  input  logic              host_wr,
  output logic              rd_en,
  output logic              wr_en,
  output logic              rd_ready_irq,
  output logic              wr_ready_irq,
  output logic              host_err
);
  import buf_trk_pkg::*;

  xfer_dir_e dir_q;
  logic      dma_q;
  logic      acc;
  logic      blk_last;
  logic      left_nz;
  logic      wr_arm;
  logic [NUM_DIR-1:0] ena_v, arm_v, flag_v, irq_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q    <= DIR_WRITE;
      dma_q    <= 1'b1;
      host_err <= 1'b0;
    end else begin
      if (xfer_start) begin
        dir_q <= xfer_dir_e'(xfer_dir_rd);
        dma_q <= dma_mode;
      end
      host_err <= (host_rd && !rd_en) || (host_wr && !wr_en);
    end
  end

  always_comb begin
    acc    = !xfer_start &&
             ((dir_q == DIR_READ) ? (host_rd && rd_en) : (host_wr && wr_en));
    wr_arm = !xfer_dir_rd && !dma_mode && (blk_total != '0);
    ena_v[DIR_READ]  = !dma_q && (dir_q == DIR_READ);
    ena_v[DIR_WRITE] = !dma_q && (dir_q == DIR_WRITE);
    arm_v[DIR_READ]  = 1'b0;
    arm_v[DIR_WRITE] = wr_arm;
  end

  btk_word_ctr #(.SIZE_W(SIZE_W)) u_words (
    .clk(clk), .rst_n(rst_n), .clr(xfer_start), .acc(acc),
    .size(blk_words), .blk_last(blk_last)
  );

  btk_blk_ctr #(.CNT_W(CNT_W)) u_blocks (
    .clk(clk), .rst_n(rst_n), .load(xfer_start), .load_val(blk_total),
    .dec(blk_last), .left_nz(left_nz)
  );

  for (genvar g = 0; g < NUM_DIR; g++) begin : g_flag
    btk_flag #(.QUEUE_WHILE_SET(g == int'(DIR_READ))) u_flag (
      .clk(clk), .rst_n(rst_n), .clr(xfer_start), .arm(arm_v[g]),
      .ena(ena_v[g]), .event_in(card_blk_done), .blk_done(blk_last),
      .left_nz(left_nz), .flag(flag_v[g]), .irq(irq_v[g])
    );
  end

  always_comb begin
    rd_en        = flag_v[DIR_READ];
    wr_en        = flag_v[DIR_WRITE];
    rd_ready_irq = irq_v[DIR_READ];
    wr_ready_irq = irq_v[DIR_WRITE];
  end
endmodule

// File: rtl/btk_checker.sv
module btk_checker (
  input logic clk,
  input logic rst_n,
  input logic xfer_start,
  input logic host_rd,
  input logic host_wr,
  input logic rd_en,
  input logic wr_en,
  input logic rd_ready_irq,
  input logic wr_ready_irq,
  input logic host_err,
  input logic blk_last,
  input logic left_nz,
  input logic dma_q
);
  p_rd_irq_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready_irq |-> (rd_en && !$past(rd_en)));

  p_wr_irq_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready_irq |-> (wr_en && !$past(wr_en)));

  p_rd_fall_on_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_en) && !$past(xfer_start)) |-> $past(blk_last));

  p_wr_fall_on_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(wr_en) && !$past(xfer_start)) |-> $past(blk_last));

  p_no_rise_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rd_en) || $rose(wr_en)) |-> $past(left_nz));

  p_dma_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_q |-> (!rd_en && !wr_en && !rd_ready_irq && !wr_ready_irq));

  p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((host_rd && !rd_en) || (host_wr && !wr_en)) |=> host_err);

  p_start_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> (!rd_en && !wr_en));

  p_one_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_en, wr_en}));
endmodule

bind buf_ready_tracker btk_checker u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .host_rd(host_rd),
  .host_wr(host_wr), .rd_en(rd_en), .wr_en(wr_en),
  .rd_ready_irq(rd_ready_irq), .wr_ready_irq(wr_ready_irq),
  .host_err(host_err), .blk_last(blk_last), .left_nz(left_nz), .dma_q(dma_q)
);

// File: tb/buf_ready_tracker_test.sv
`timescale 1ns/1ps
module buf_ready_tracker_test;
  localparam int SW = 12;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xfer_start = 0, xfer_dir_rd = 0, dma_mode = 0;
  logic [SW-1:0] blk_words = '0;
  logic [CW-1:0] blk_total = '0;
  logic card_blk_done = 0, host_rd = 0, host_wr = 0;
  logic rd_en, wr_en, rd_ready_irq, wr_ready_irq, host_err;

  int n_tests = 0;
  int n_fail  = 0;

  // bench model of the flag rules
  logic m_rd = 0, m_wr = 0, m_ri = 0, m_wi = 0, m_err = 0;
  logic m_isrd = 0, m_dma = 1, m_queued = 0, m_arm = 0;
  int   m_words = 0, m_left = 0;

  always #4 clk = ~clk;

  buf_ready_tracker #(.SIZE_W(SW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start),
    .xfer_dir_rd(xfer_dir_rd), .dma_mode(dma_mode), .blk_words(blk_words),
    .blk_total(blk_total), .card_blk_done(card_blk_done),
    .host_rd(host_rd), .host_wr(host_wr), .rd_en(rd_en), .wr_en(wr_en),
    .rd_ready_irq(rd_ready_irq), .wr_ready_irq(wr_ready_irq),
    .host_err(host_err)
  );

  function automatic int block_len(int unsigned sz);
    return (sz == 0) ? 1 : int'(sz);
  endfunction

  task automatic check(string tag, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic nrd, nwr, fin;
    nrd = m_rd; nwr = m_wr; fin = 0;
    m_err = (host_rd && !m_rd) || (host_wr && !m_wr);
    m_ri = 0; m_wi = 0;
    if (xfer_start) begin
      m_rd = 0; m_wr = 0; m_words = 0; m_left = int'(blk_total);
      m_isrd = xfer_dir_rd; m_dma = dma_mode; m_queued = 0;
      m_arm = !xfer_dir_rd && !dma_mode && (blk_total != 0);
      return;
    end
    if ((m_isrd && host_rd && m_rd) || (!m_isrd && host_wr && m_wr)) begin
      m_words++;
      if (m_words == block_len(blk_words)) begin m_words = 0; fin = 1; end
    end
    if (!m_dma && m_isrd) begin
      if (m_rd) begin
        if (card_blk_done) m_queued = 1;
        if (fin) nrd = 0;
      end else if ((card_blk_done || m_queued) && m_left != 0) begin
        nrd = 1; m_ri = 1; m_queued = 0;
      end
    end
    if (!m_dma && !m_isrd) begin
      if (m_wr) begin
        if (fin) nwr = 0;
      end else if ((card_blk_done || m_arm) && m_left != 0) begin
        nwr = 1; m_wi = 1; m_arm = 0;
      end
    end
    if (fin && m_left != 0) m_left--;
    m_rd = nrd; m_wr = nwr;
  endtask

  // one clock: inputs already driven; model follows the edge; outputs compared
  task automatic tick();
    @(posedge clk);
    model_step();
    #1;
    check("R2/R3/R9 rd_en model", rd_en, m_rd);
    check("R4/R5/R10 wr_en model", wr_en, m_wr);
    check("R2 rd_ready_irq model", rd_ready_irq, m_ri);
    check("R4 wr_ready_irq model", wr_ready_irq, m_wi);
    check("R8 host_err model", host_err, m_err);
    @(negedge clk);
    xfer_start = 0; card_blk_done = 0; host_rd = 0; host_wr = 0;
  endtask

  task automatic start(logic rd, logic dma, int words, int total);
    xfer_start = 1; xfer_dir_rd = rd; dma_mode = dma;
    blk_words = SW'(words); blk_total = CW'(total);
    tick();
  endtask

  task automatic rd_n(int n);
    for (int i = 0; i < n; i++) begin host_rd = 1; tick(); end
  endtask

  task automatic wr_n(int n);
    for (int i = 0; i < n; i++) begin host_wr = 1; tick(); end
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    check("R1 rd_en in reset", rd_en, 1'b0);
    check("R1 wr_en in reset", wr_en, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    check("R1 rd_ready_irq after reset", rd_ready_irq, 1'b0);
    check("R1 host_err after reset", host_err, 1'b0);

    // read transfer: 4 words, 3 blocks
    start(1, 0, 4, 3);
    check("R11 rd_en after start", rd_en, 1'b0);
    host_rd = 1; tick();
    check("R8 read while empty raises err", host_err, 1'b1);
    card_blk_done = 1; tick();
    check("R2 rd_en rises", rd_en, 1'b1);
    check("R2 irq with rise", rd_ready_irq, 1'b1);
    tick();
    check("R2 irq one cycle", rd_ready_irq, 1'b0);
    rd_n(3);
    check("R3 rd_en held before last word", rd_en, 1'b1);
    rd_n(1);
    check("R3 rd_en falls after last word", rd_en, 1'b0);
    card_blk_done = 1; tick();
    check("R2 second block rises", rd_en, 1'b1);
    rd_n(3);
    host_rd = 1; card_blk_done = 1; tick();
    check("R9 falls on last word with coincident done", rd_en, 1'b0);
    tick();
    check("R9 re-rise from held done", rd_en, 1'b1);
    check("R9 irq on re-rise", rd_ready_irq, 1'b1);
    rd_n(4);
    check("R3 third block drained", rd_en, 1'b0);
    card_blk_done = 1; tick();
    check("R6 no rise after last block", rd_en, 1'b0);
    check("R6 no irq after last block", rd_ready_irq, 1'b0);

    // write transfer: 4 words, 2 blocks
    start(0, 0, 4, 2);
    check("R4 wr_en not yet", wr_en, 1'b0);
    tick();
    check("R4 wr_en rises", wr_en, 1'b1);
    check("R4 irq with rise", wr_ready_irq, 1'b1);
    card_blk_done = 1; tick();
    check("R10 done while set ignored", wr_ready_irq, 1'b0);
    wr_n(4);
    check("R5 wr_en falls after last word", wr_en, 1'b0);
    tick();
    check("R10 no later rise from discarded done", wr_en, 1'b0);
    card_blk_done = 1; tick();
    check("R5 re-rise on card drain", wr_en, 1'b1);
    check("R5 irq on re-rise", wr_ready_irq, 1'b1);
    wr_n(4);
    card_blk_done = 1; tick();
    check("R6 write stays low at zero blocks", wr_en, 1'b0);

    // DMA transfers
    start(1, 1, 4, 2);
    card_blk_done = 1; tick();
    check("R7 rd_en stays low in DMA", rd_en, 1'b0);
    check("R7 no read irq in DMA", rd_ready_irq, 1'b0);
    host_rd = 1; tick();
    check("R7 host read in DMA flagged", host_err, 1'b1);
    start(0, 1, 4, 2);
    tick(); tick();
    check("R7 wr_en stays low in DMA", wr_en, 1'b0);

    // restart in the middle of a block
    start(1, 0, 4, 5);
    card_blk_done = 1; tick();
    rd_n(2);
    start(1, 0, 4, 5);
    check("R11 restart clears rd_en", rd_en, 1'b0);
    card_blk_done = 1; tick();
    rd_n(3);
    check("R11 word count restarted", rd_en, 1'b1);
    rd_n(1);
    check("R11 block ends after full count", rd_en, 1'b0);

    // zero block size counts as one word
    start(1, 0, 0, 2);
    card_blk_done = 1; tick();
    rd_n(1);
    check("R3 size zero drains in one word", rd_en, 1'b0);

    // constrained random traffic against the model
    for (int c = 0; c < 5000; c++) begin
      if ($urandom % 40 == 0) begin
        xfer_start  = 1;
        xfer_dir_rd = 1'($urandom % 2);
        dma_mode    = ($urandom % 5 == 0);
        blk_words   = SW'($urandom % 5);
        blk_total   = CW'($urandom % 4);
      end
      card_blk_done = ($urandom % 6 == 0);
      host_rd       = ($urandom % 3 == 0);
      host_wr       = ($urandom % 3 == 0);
      tick();
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule